// File: doc/BRIEF.md
# Prescaled 16-bit Overflow Timer

This block keeps a 16-bit count that runs freely from the moment reset is released. The count advances once per tick of a prescaler. The prescaler divides the system clock by 1, 4, 8 or 16, and a two-bit field in a control register selects the ratio. That field can only be changed during a short window after reset. After the window closes, the ratio is fixed until the next reset.

When the count rolls over from its top value back to zero, a sticky overflow bit is set in a status register. The interrupt output is raised while that bit and its enable bit are both set. A small byte-wide register port gives the following access:
- The count can be read as two bytes.
- The control register can be written and read back.
- The status register is cleared by writing ones to the bits to clear.

Reading the high byte captures the low byte at the same instant, so a two-read sequence returns one coherent 16-bit value. The running count is also exported on its own output for neighbouring capture and compare logic.

Top module: `ovf_timer16`

## Requirements
- R1: The divider field is control bits [1:0]. Encoding 00 gives one count step per clock, 01 one step per 4 clocks, 10 one per 8 and 11 one per 16.
- R2: Control bits [1:0] accept writes only during the first LOCK_CYCLES (default 64) clocks after reset. A later control write updates bits [7:2] and leaves bits [1:0] and the division ratio unchanged.
- R3: The count increases by exactly one per prescaler tick, holds between ticks, and wraps from 0xFFFF to 0x0000.
- R4: The wrap from 0xFFFF to 0x0000 sets status bit 7, which reads back as 0x80.
- R5: A read at register address 0 returns count[15:8]. A read at address 1 returns count[7:0] (the live value when no capture is pending).
- R6: A read at address 0 captures count[7:0] at that clock. The next read at address 1 returns the captured byte instead of the live one, and the capture is then consumed.
- R7: Writing the status register (address 3) clears only the bits written as 1. Bits written as 0 are left unchanged. A wrap in the same clock as a clear keeps bit 7 set.
- R8: irq_o is high exactly when status bit 7 and control bit 7 (the overflow interrupt enable, control register at address 2) are both set.
- R9: After reset the count is 0, the ratio is divide-by-1, and the control register, status register and irq_o are all zero.
- R10: A new divider selection written inside the window takes effect at the next prescaler tick, and the prescaler phase restarts from zero at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 count high, 1 count low, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the same cycle |
| count_o | output | 16 | Running count for capture and compare logic |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Read data is combinational, so each read is scored at the falling edge inside the strobe cycle. A write becomes visible in registers and in irq_o right after the clock edge that accepts it. The count moves one clock edge after each prescaler tick, and a new divider ratio is active from the tick after the control write. For that reason, ratio checks wait a few cycles and then compare two falling-edge samples a whole number of periods apart. The wrap is caught by sampling at the falling edge where the count shows 0xFFFF. The flag, the count of zero and the interrupt are then checked just after the following rising edge.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

   localparam int BYTE_W  = 8;
   localparam int SEL_W   = 2;
   localparam int OVF_BIT = 7;

   typedef enum logic [1:0] {
      RA_CNT_HI = 2'd0,
      RA_CNT_LO = 2'd1,
      RA_CTRL   = 2'd2,
      RA_STAT   = 2'd3
   } reg_addr_e;

   function automatic int unsigned div_ratio(logic [SEL_W-1:0] sel);
      int unsigned r;
      case (sel)
         2'b00:   r = 1;
         2'b01:   r = 4;
         2'b10:   r = 8;
         default: r = 16;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ovf_prescale.sv
module ovf_prescale
   import ovf_timer_pkg::*;
#(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_req_i,
   output logic             tick_o
);

   if (DIV_W < 4) begin : g_bad_div_w
      $error("ovf_prescale: DIV_W must hold a ratio of 16");
   end

   logic [DIV_W-1:0] div_q;
   logic [SEL_W-1:0] sel_act_q;
   logic [DIV_W-1:0] terminal;

   always_comb terminal = DIV_W'(div_ratio(sel_act_q) - 1);

   assign tick_o = (div_q == terminal);

   // The selection only changes at a tick boundary, and the phase restarts there
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q     <= '0;
         sel_act_q <= '0;
      end else if (tick_o) begin
         div_q     <= '0;
         sel_act_q <= sel_req_i;
      end else begin
         div_q     <= div_q + 1'b1;
      end
   end

   // R1: with any ratio above one, two ticks are never adjacent
   p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && sel_req_i != 2'b00) |=> !tick_o);

endmodule

// File: rtl/ovf_counter.sv
module ovf_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("ovf_counter: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;
   assign wrap_o  = tick_i & (&cnt_q);

   // R3: the count never moves without a prescaler tick
   p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/ovf_regs.sv
module ovf_regs
   import ovf_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int LOCK_CYCLES = 64,
   parameter bit LATCH_LOW   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [1:0]        addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              wrap_i,
   output logic [SEL_W-1:0]  sel_o,
   output logic              irq_o
);

   localparam int WIN_W = $clog2(LOCK_CYCLES + 1);

   logic [WIN_W-1:0]  win_q;
   logic              win_open;
   logic [BYTE_W-1:0] ctrl_q;
   logic [BYTE_W-1:0] stat_q;
   logic [BYTE_W-1:0] stat_nxt;
   logic [BYTE_W-1:0] lo_byte;
   logic              wr_ctrl, wr_stat;

   assign win_open = (win_q < WIN_W'(LOCK_CYCLES));
   assign wr_ctrl  = we_i && (addr_i == RA_CTRL);
   assign wr_stat  = we_i && (addr_i == RA_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n)        win_q <= '0;
      else if (win_open) win_q <= win_q + 1'b1;
   end

   // Divider field is frozen once the window closes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         if (win_open) ctrl_q <= wdata_i;
         else          ctrl_q <= {wdata_i[BYTE_W-1:SEL_W], ctrl_q[SEL_W-1:0]};
      end
   end

   always_comb begin
      stat_nxt = stat_q;
      if (wr_stat) stat_nxt = stat_q & ~wdata_i;
      if (wrap_i)  stat_nxt[OVF_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_nxt;
   end

   if (LATCH_LOW) begin : g_latch
      logic [BYTE_W-1:0] lo_q;
      logic              lo_vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q     <= '0;
            lo_vld_q <= 1'b0;
         end else if (re_i && addr_i == RA_CNT_HI) begin
            lo_q     <= count_i[BYTE_W-1:0];
            lo_vld_q <= 1'b1;
         end else if (re_i && addr_i == RA_CNT_LO) begin
            lo_vld_q <= 1'b0;
         end
      end
      assign lo_byte = lo_vld_q ? lo_q : count_i[BYTE_W-1:0];
   end else begin : g_live
      assign lo_byte = count_i[BYTE_W-1:0];
   end

   always_comb begin
      case (addr_i)
         RA_CNT_HI: rdata_o = count_i[CNT_W-1:BYTE_W];
         RA_CNT_LO: rdata_o = lo_byte;
         RA_CTRL:   rdata_o = ctrl_q;
         default:   rdata_o = stat_q;
      endcase
   end

   assign sel_o = ctrl_q[SEL_W-1:0];
   assign irq_o = stat_q[OVF_BIT] & ctrl_q[OVF_BIT];

   // R2: divider bits hold still after the write window
   p_sel_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |=> $stable(ctrl_q[SEL_W-1:0]));

   // R4: a wrap from the counter always leaves the flag set
   p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> stat_q[OVF_BIT]);

   // R7: the flag only drops on a write of one to it
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[OVF_BIT] && !(wr_stat && wdata_i[OVF_BIT])) |=> stat_q[OVF_BIT]);

endmodule

// File: rtl/ovf_timer16.sv
module ovf_timer16
   import ovf_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV_W       = 4,
   parameter int LOCK_CYCLES = 64,
   parameter bit LATCH_LOW   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic             bus_re,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);

   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("ovf_timer16: count must be exactly two bytes");
   end
   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("ovf_timer16: LOCK_CYCLES must be positive");
   end

   logic             tick;
   logic             wrap;
   logic [SEL_W-1:0] sel;

   ovf_prescale #(.DIV_W(DIV_W)) u_prescale (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_req_i (sel),
      .tick_o    (tick)
   );

   ovf_counter #(.CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .count_o (count_o),
      .wrap_o  (wrap)
   );

   ovf_regs #(
      .CNT_W       (CNT_W),
      .LOCK_CYCLES (LOCK_CYCLES),
      .LATCH_LOW   (LATCH_LOW)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bus_we),
      .re_i    (bus_re),
      .addr_i  (bus_addr),
      .wdata_i (bus_wdata),
      .rdata_o (bus_rdata),
      .count_i (count_o),
      .wrap_i  (wrap),
      .sel_o   (sel),
      .irq_o   (irq_o)
   );

endmodule

// File: tb/test_ovf_timer16.sv
module test_ovf_timer16;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  bus_wdata = 8'd0;
   logic [7:0]  bus_rdata;
   logic [15:0] count_o;
   logic        irq_o;

   typedef struct {
      string      req;
      logic [7:0] exp_v;
   } item_t;

   item_t sb_q[$];
   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ovf_timer16 i_ovf_timer16 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .count_o   (count_o),
      .irq_o     (irq_o)
   );

   // Monitor: scores every read strobe against the head of the queue
   always @(negedge clk) begin
      if (rst_n && bus_re && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_checks++;
         if (bus_rdata !== it.exp_v) begin
            n_errors++;
            $display("FAIL %s: read addr %0d actual=%h expected=%h",
                     it.req, bus_addr, bus_rdata, it.exp_v);
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, logic [7:0] exp_v, string req);
      item_t it;
      it.req = req; it.exp_v = exp_v;
      @(posedge clk); #1;
      sb_q.push_back(it);
      bus_re = 1'b1; bus_addr = a;
      @(posedge clk); #1;
      bus_re = 1'b0;
   endtask

   // Read of a count byte whose expected value is the live count in that cycle
   task automatic read_live(logic [1:0] a, string req, output logic [7:0] lo_seen);
      item_t it;
      @(posedge clk); #1;
      bus_re = 1'b1; bus_addr = a;
      #1;
      lo_seen  = count_o[7:0];
      it.req   = req;
      it.exp_v = (a == 2'd0) ? count_o[15:8] : count_o[7:0];
      sb_q.push_back(it);
      @(posedge clk); #1;
      bus_re = 1'b0;
   endtask

   task automatic measure(int n, int steps, string req);
      logic [15:0] c0;
      @(negedge clk); c0 = count_o;
      repeat (n) @(negedge clk);
      check(req, 32'(count_o - c0), 32'(steps));
   endtask

   initial begin
      logic [7:0] lo_snap, dummy;
      do_reset();
      // R9: reset state
      check("R9 count", 32'(count_o), 0);
      check("R9 irq", 32'(irq_o), 0);
      bus_read(2'd2, 8'h00, "R9 ctrl");
      bus_read(2'd3, 8'h00, "R9 stat");
      // R1: divide by 1 after reset
      measure(20, 20, "R1 div1");
      // R5, R6: high read captures low byte; later low read returns the capture
      read_live(2'd0, "R5 high byte", lo_snap);
      repeat (5) @(posedge clk);
      bus_read(2'd1, lo_snap, "R6 latched low");
      read_live(2'd1, "R5 live low", dummy);

      // R1, R10: each ratio written inside the window
      do_reset();
      bus_write(2'd2, 8'h01);
      bus_read(2'd2, 8'h01, "R2 ctrl write in window");
      repeat (3) @(posedge clk);
      measure(64, 16, "R1 R10 div4");
      do_reset();
      bus_write(2'd2, 8'h02);
      repeat (3) @(posedge clk);
      measure(64, 8, "R1 R10 div8");
      do_reset();
      bus_write(2'd2, 8'h03);
      repeat (3) @(posedge clk);
      measure(64, 4, "R1 R10 div16");

      // R2: lock after window
      do_reset();
      repeat (70) @(posedge clk);
      bus_write(2'd2, 8'h83);
      bus_read(2'd2, 8'h80, "R2 locked sel bits");
      repeat (3) @(posedge clk);
      measure(32, 32, "R2 ratio unchanged");
      bus_read(2'd3, 8'h00, "R4 no flag before wrap");

      // R3, R4, R8: wrap
      @(negedge clk);
      while (count_o != 16'hFFFF) @(negedge clk);
      @(posedge clk); #1;
      check("R3 wrap to zero", 32'(count_o), 0);
      check("R8 irq on wrap", 32'(irq_o), 1);
      bus_read(2'd3, 8'h80, "R4 flag set");
      // R7: zero write leaves the flag
      bus_write(2'd3, 8'h00);
      bus_read(2'd3, 8'h80, "R7 zero write no clear");
      // R8: enable gates irq
      bus_write(2'd2, 8'h00);
      check("R8 irq masked", 32'(irq_o), 0);
      bus_write(2'd2, 8'h80);
      check("R8 irq re-enabled", 32'(irq_o), 1);
      // R7: one clears
      bus_write(2'd3, 8'h80);
      check("R7 irq after clear", 32'(irq_o), 0);
      bus_read(2'd3, 8'h00, "R7 flag cleared");

      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule